// File: doc/BRIEF.md
# Indexed-Colour Display Register Bank

This block is the control-register front end of an indexed-colour display controller. A processor reaches it over a simple 32-bit memory-mapped bus that carries an address, a byte-enable mask, a write strobe, a read strobe and write data. Only full-word accesses take effect. The block keeps the display geometry, a control word, the frame-buffer start offset and the cursor location. It also holds three lookup tables: the 256-entry pixel colour table, the 3-entry cursor colour table and the 512-word cursor shape table. Read ports on these tables feed the pixel engine.

Geometry is held in scaled form. The horizontal register takes a count of 4-pixel groups. The vertical register takes twice the line count. The pixel engine sees true pixel and line counts. A 3-bit field in the control word selects the pixel depth through a fixed table.

A frame-done pulse from the display side raises an interrupt, and any register write by the processor lowers it. A sticky dirty flag tells the pixel engine that table contents have changed, and the flag stays up until the pixel engine acknowledges it. A write to the soft-reset address returns all state to its power-up values.

Top module: `dispctl_regbank`

## Requirements
- R1: After reset every geometry, control, offset and cursor output is zero, `irq` and `disp_dirty` are low, and all three table read ports return zero.
- R2: A full-word write of N to byte address 0x118 sets `width_px` to 4*N, truncated to 12 bits. A read of 0x118 returns `width_px`/4.
- R3: A full-word write of N to 0x150 sets `height_ln` to N/2, rounded down. A read of 0x150 returns 2*`height_ln`.
- R4: A write to 0x300 stores the full 32-bit control word, and reads of 0x300 return it. `depth_bpp` is 1, 2, 4, 8, 15, 16, 0, 0 for control bits 22:20 equal to 0 through 7. `blank_force` is control bit 10 and `cursor_hide` is control bit 23.
- R5: A write to 0x400 sets `top_ofs` from data bits 23:0. A write to 0x638 sets `cursor_x` from data bits 23:12 and `cursor_y` from data bits 11:0.
- R6: A write anywhere in 0x800–0xFFF stores data bits 23:0 (red 23:16, green 15:8, blue 7:0) in colour entry (address−0x800)>>3.
- R7: A write anywhere in 0x508–0x51F stores data bits 23:0 in cursor colour entry (address−0x508)>>3, for entries 0 to 2. Read index 3 returns zero.
- R8: A write anywhere in 0x1000–0x1FFF stores data bits 15:0 in shape entry (address−0x1000)>>3.
- R9: Writes to 0x000, 0x108, 0x110, 0x120–0x148 (every 8 bytes), 0x158, 0x160, 0x168, 0x170 and 0x200 change no state. A read returns data in the cycle after the read strobe. A read of any address other than 0x118, 0x150 and 0x300 returns zero and raises `bus_err` for exactly that one cycle.
- R10: An access whose byte-enable mask is not 4'hF is ignored. It changes no state, does not lower `irq`, returns zero read data and does not raise `bus_err`.
- R11: A write to 0x100000 clears all three tables, the control word, the offset, the cursor position and the geometry, lowers `irq` and sets `disp_dirty`.
- R12: A `frame_done` pulse sets `irq`. Any full-word write clears `irq`. When both happen in the same cycle, `irq` is set.
- R13: A write to any table, or a soft reset, sets `disp_dirty`. `dirty_ack` clears it. When both happen in the same cycle, `disp_dirty` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 21 | Byte address |
| bus_be | input | 4 | Byte-enable mask; only 4'hF acts |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_err | output | 1 | Read-error pulse, aligned with `bus_rdata` |
| frame_done | input | 1 | End-of-frame pulse from the display side |
| dirty_ack | input | 1 | Display side has consumed the table changes |
| irq | output | 1 | Frame interrupt |
| disp_dirty | output | 1 | Sticky table-changed flag |
| width_px | output | 12 | Visible width in pixels |
| height_ln | output | 12 | Visible height in lines |
| ctrl_word | output | 32 | Control word |
| depth_bpp | output | 5 | Decoded bits per pixel |
| blank_force | output | 1 | Forced-blank control bit |
| cursor_hide | output | 1 | Cursor-disable control bit |
| top_ofs | output | 24 | Frame-buffer start offset |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| pal_ridx | input | 8 | Colour table read index |
| pal_rgb | output | 24 | Colour table entry |
| cpal_ridx | input | 2 | Cursor colour read index |
| cpal_rgb | output | 24 | Cursor colour entry |
| pat_ridx | input | 9 | Shape table read index |
| pat_word | output | 16 | Shape table entry |

## Verification
The assertions assume that every input is at a known level once reset is released, and that `frame_done` and `dirty_ack` are driven by the display clock domain already synchronised to `clk`. The error and dirty checks also assume that the processor presents at most one access per cycle. The stimulus meets these assumptions by changing inputs only on the falling clock edge, by issuing each access as a single-cycle strobe followed by an idle cycle, and by holding every input at a defined value from time zero.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int BUS_ADDR_W = 21;
    localparam int TAB_IDX_W  = 9;

    localparam int OFS_WIDTH  = 'h000118;
    localparam int OFS_HEIGHT = 'h000150;
    localparam int OFS_CTRL   = 'h000300;
    localparam int OFS_TOP    = 'h000400;
    localparam int OFS_CPAL   = 'h000508;
    localparam int OFS_CPOS   = 'h000638;
    localparam int OFS_PAL    = 'h000800;
    localparam int OFS_PAT    = 'h001000;
    localparam int OFS_SRST   = 'h100000;

    localparam int SPAN_CPAL  = 'h18;
    localparam int SPAN_PAL   = 'h800;
    localparam int SPAN_PAT   = 'h1000;

    typedef enum logic [3:0] {
        K_NONE, K_IGNORE, K_WIDTH, K_HEIGHT, K_CTRL, K_TOP,
        K_CPOS, K_CPAL, K_PAL, K_PAT, K_SRST
    } reg_kind_e;

    function automatic logic [4:0] depth_of(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd15;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/dispctl_addr_decode.sv
module dispctl_addr_decode
    import dispctl_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic [ADDR_W-1:0]    addr,
    output reg_kind_e            kind,
    output logic [TAB_IDX_W-1:0] index
);
    localparam logic [ADDR_W-1:0] PAL_LO  = ADDR_W'(OFS_PAL);
    localparam logic [ADDR_W-1:0] PAL_HI  = ADDR_W'(OFS_PAL + SPAN_PAL);
    localparam logic [ADDR_W-1:0] PAT_LO  = ADDR_W'(OFS_PAT);
    localparam logic [ADDR_W-1:0] PAT_HI  = ADDR_W'(OFS_PAT + SPAN_PAT);
    localparam logic [ADDR_W-1:0] CPAL_LO = ADDR_W'(OFS_CPAL);
    localparam logic [ADDR_W-1:0] CPAL_HI = ADDR_W'(OFS_CPAL + SPAN_CPAL);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        kind  = K_NONE;
        index = '0;
        rel   = '0;
        if (addr >= PAL_LO && addr < PAL_HI) begin
            rel   = addr - PAL_LO;
            kind  = K_PAL;
            index = {1'b0, rel[10:3]};
        end else if (addr >= PAT_LO && addr < PAT_HI) begin
            rel   = addr - PAT_LO;
            kind  = K_PAT;
            index = rel[11:3];
        end else if (addr >= CPAL_LO && addr < CPAL_HI) begin
            rel   = addr - CPAL_LO;
            kind  = K_CPAL;
            index = {7'd0, rel[4:3]};
        end else begin
            case (addr)
                ADDR_W'(OFS_WIDTH):  kind = K_WIDTH;
                ADDR_W'(OFS_HEIGHT): kind = K_HEIGHT;
                ADDR_W'(OFS_CTRL):   kind = K_CTRL;
                ADDR_W'(OFS_TOP):    kind = K_TOP;
                ADDR_W'(OFS_CPOS):   kind = K_CPOS;
                ADDR_W'(OFS_SRST):   kind = K_SRST;
                ADDR_W'('h000), ADDR_W'('h108), ADDR_W'('h110),
                ADDR_W'('h120), ADDR_W'('h128), ADDR_W'('h130),
                ADDR_W'('h138), ADDR_W'('h140), ADDR_W'('h148),
                ADDR_W'('h158), ADDR_W'('h160), ADDR_W'('h168),
                ADDR_W'('h170), ADDR_W'('h200): kind = K_IGNORE;
                default:             kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dispctl_lut_store.sv
module dispctl_lut_store #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (clr) begin
                mem_d[i] = '0;
            end else if (we && int'(widx) == i) begin
                mem_d[i] = wdata;
            end else begin
                mem_d[i] = mem_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(ridx) == i) rdata = mem_q[i];
        end
    end

    // R11: a clear leaves the first and last entries empty
    a_r11_table_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem_q[0] == '0 && mem_q[DEPTH-1] == '0));

    // R6: a write to entry 0 is visible there one cycle later
    a_r6_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && widx == '0) |=> (mem_q[0] == $past(wdata)));

endmodule

// File: rtl/dispctl_regbank.sv
module dispctl_regbank
    import dispctl_pkg::*;
#(
    parameter int ADDR_W  = BUS_ADDR_W,
    parameter int WPX_W   = 12,
    parameter int HT_W    = 12,
    parameter int TOP_W   = 24,
    parameter int CPOS_W  = 24,
    parameter int PAL_N   = 256,
    parameter int CPAL_N  = 3,
    parameter int PAT_N   = 512,
    parameter int RGB_W   = 24,
    parameter int PAT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [3:0]                bus_be,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_err,
    input  logic                      frame_done,
    input  logic                      dirty_ack,
    output logic                      irq,
    output logic                      disp_dirty,
    output logic [WPX_W-1:0]          width_px,
    output logic [HT_W-1:0]           height_ln,
    output logic [31:0]               ctrl_word,
    output logic [4:0]                depth_bpp,
    output logic                      blank_force,
    output logic                      cursor_hide,
    output logic [TOP_W-1:0]          top_ofs,
    output logic [CPOS_W/2-1:0]       cursor_x,
    output logic [CPOS_W/2-1:0]       cursor_y,
    input  logic [$clog2(PAL_N)-1:0]  pal_ridx,
    output logic [RGB_W-1:0]          pal_rgb,
    input  logic [$clog2(CPAL_N)-1:0] cpal_ridx,
    output logic [RGB_W-1:0]          cpal_rgb,
    input  logic [$clog2(PAT_N)-1:0]  pat_ridx,
    output logic [PAT_W-1:0]          pat_word
);
    localparam int PAL_IW  = $clog2(PAL_N);
    localparam int CPAL_IW = $clog2(CPAL_N);
    localparam int PAT_IW  = $clog2(PAT_N);
    localparam int HALF    = CPOS_W / 2;

    typedef struct packed {
        logic [WPX_W-1:0]  width_px;
        logic [HT_W-1:0]   height_ln;
        logic [31:0]       ctrl;
        logic [TOP_W-1:0]  top;
        logic [CPOS_W-1:0] cpos;
        logic              irq;
        logic              dirty;
        logic [31:0]       rdata;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    reg_kind_e              kind;
    logic [TAB_IDX_W-1:0]   tab_idx;
    logic                   full_word, wr_ok, rd_ok, tab_clr;

    dispctl_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (bus_addr),
        .kind  (kind),
        .index (tab_idx)
    );

    assign full_word = (bus_be == 4'hF);
    assign wr_ok     = bus_wr && full_word;
    assign rd_ok     = bus_rd && full_word;
    assign tab_clr   = wr_ok && (kind == K_SRST);

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        s_d.err   = 1'b0;

        if (dirty_ack) s_d.dirty = 1'b0;

        if (wr_ok) begin
            s_d.irq = 1'b0;
            case (kind)
                K_WIDTH:  s_d.width_px  = {bus_wdata[WPX_W-3:0], 2'b00};
                K_HEIGHT: s_d.height_ln = bus_wdata[HT_W:1];
                K_CTRL:   s_d.ctrl      = bus_wdata;
                K_TOP:    s_d.top       = bus_wdata[TOP_W-1:0];
                K_CPOS:   s_d.cpos      = bus_wdata[CPOS_W-1:0];
                K_PAL, K_CPAL, K_PAT: s_d.dirty = 1'b1;
                K_SRST: begin
                    s_d.width_px  = '0;
                    s_d.height_ln = '0;
                    s_d.ctrl      = '0;
                    s_d.top       = '0;
                    s_d.cpos      = '0;
                    s_d.dirty     = 1'b1;
                end
                default: ;
            endcase
        end

        if (frame_done) s_d.irq = 1'b1;

        if (rd_ok) begin
            case (kind)
                K_WIDTH:  s_d.rdata = 32'(s_q.width_px[WPX_W-1:2]);
                K_HEIGHT: s_d.rdata = 32'({s_q.height_ln, 1'b0});
                K_CTRL:   s_d.rdata = s_q.ctrl;
                default:  s_d.err   = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dispctl_lut_store #(.DEPTH(PAL_N), .WIDTH(RGB_W)) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tab_clr),
        .we    (wr_ok && kind == K_PAL),
        .widx  (tab_idx[PAL_IW-1:0]),
        .wdata (bus_wdata[RGB_W-1:0]),
        .ridx  (pal_ridx),
        .rdata (pal_rgb)
    );

    dispctl_lut_store #(.DEPTH(CPAL_N), .WIDTH(RGB_W)) u_cpal (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tab_clr),
        .we    (wr_ok && kind == K_CPAL),
        .widx  (tab_idx[CPAL_IW-1:0]),
        .wdata (bus_wdata[RGB_W-1:0]),
        .ridx  (cpal_ridx),
        .rdata (cpal_rgb)
    );

    dispctl_lut_store #(.DEPTH(PAT_N), .WIDTH(PAT_W)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tab_clr),
        .we    (wr_ok && kind == K_PAT),
        .widx  (tab_idx[PAT_IW-1:0]),
        .wdata (bus_wdata[PAT_W-1:0]),
        .ridx  (pat_ridx),
        .rdata (pat_word)
    );

    assign bus_rdata   = s_q.rdata;
    assign bus_err     = s_q.err;
    assign irq         = s_q.irq;
    assign disp_dirty  = s_q.dirty;
    assign width_px    = s_q.width_px;
    assign height_ln   = s_q.height_ln;
    assign ctrl_word   = s_q.ctrl;
    assign depth_bpp   = depth_of(s_q.ctrl[22:20]);
    assign blank_force = s_q.ctrl[10];
    assign cursor_hide = s_q.ctrl[23];
    assign top_ofs     = s_q.top;
    assign cursor_x    = s_q.cpos[CPOS_W-1:HALF];
    assign cursor_y    = s_q.cpos[HALF-1:0];

    a_r12_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> irq);

    a_r12_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !frame_done) |=> !irq);

    a_r11_regs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tab_clr |=> (width_px == '0 && height_ln == '0 && ctrl_word == '0
                     && top_ofs == '0 && !irq == !$past(frame_done)));

    a_r13_dirty_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && kind inside {K_PAL, K_CPAL, K_PAT, K_SRST}) |=> disp_dirty);

    a_r13_dirty_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_ack && !(wr_ok && kind inside {K_PAL, K_CPAL, K_PAT, K_SRST}))
        |=> !disp_dirty);

    a_r9_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd));

    a_r10_partial_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !full_word && !frame_done)
        |=> ($stable(ctrl_word) && $stable(irq) && $stable(width_px)));

endmodule

// File: tb/test_dispctl_regbank.sv
`timescale 1ns/1ps
module test_dispctl_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        frame_done = 1'b0;
    logic        dirty_ack = 1'b0;
    logic        irq, disp_dirty;
    logic [11:0] width_px, height_ln;
    logic [31:0] ctrl_word;
    logic [4:0]  depth_bpp;
    logic        blank_force, cursor_hide;
    logic [23:0] top_ofs;
    logic [11:0] cursor_x, cursor_y;
    logic [7:0]  pal_ridx = '0;
    logic [23:0] pal_rgb;
    logic [1:0]  cpal_ridx = '0;
    logic [23:0] cpal_rgb;
    logic [8:0]  pat_ridx = '0;
    logic [15:0] pat_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dispctl_regbank i_dispctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .frame_done(frame_done),
        .dirty_ack(dirty_ack), .irq(irq), .disp_dirty(disp_dirty),
        .width_px(width_px), .height_ln(height_ln), .ctrl_word(ctrl_word),
        .depth_bpp(depth_bpp), .blank_force(blank_force),
        .cursor_hide(cursor_hide), .top_ofs(top_ofs), .cursor_x(cursor_x),
        .cursor_y(cursor_y), .pal_ridx(pal_ridx), .pal_rgb(pal_rgb),
        .cpal_ridx(cpal_ridx), .cpal_rgb(cpal_rgb), .pat_ridx(pat_ridx),
        .pat_word(pat_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_depth(input int code);
        int tbl [8] = '{1, 2, 4, 8, 15, 16, 0, 0};
        return 5'(tbl[code]);
    endfunction

    task automatic wr(input logic [20:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [20:0] a, output logic [31:0] d, output logic e,
                      input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata; e = bus_err;
        bus_rd = 1'b0; bus_be = 4'hF;
    endtask

    task automatic t_reset_state;
        chk("R1 width", 32'(width_px), 0);
        chk("R1 height", 32'(height_ln), 0);
        chk("R1 ctrl", ctrl_word, 0);
        chk("R1 top", 32'(top_ofs), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dirty", 32'(disp_dirty), 0);
        pal_ridx = 8'd17; cpal_ridx = 2'd1; pat_ridx = 9'd300; #1;
        chk("R1 pal", 32'(pal_rgb), 0);
        chk("R1 cpal", 32'(cpal_rgb), 0);
        chk("R1 pat", 32'(pat_word), 0);
    endtask

    task automatic t_width;
        logic [31:0] d; logic e;
        wr(21'h118, 32'h50);
        chk("R2 width px", 32'(width_px), 32'h140);
        rd(21'h118, d, e);
        chk("R2 width read", d, 32'h50);
        chk("R2 no err", 32'(e), 0);
        wr(21'h118, 32'h3FF);
        chk("R2 width max", 32'(width_px), 32'hFFC);
        rd(21'h118, d, e);
        chk("R2 width max read", d, 32'h3FF);
    endtask

    task automatic t_height;
        logic [31:0] d; logic e;
        wr(21'h150, 32'h3C1);
        chk("R3 height odd", 32'(height_ln), 32'h1E0);
        rd(21'h150, d, e);
        chk("R3 height read", d, 32'h3C0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d; logic e;
        for (int c = 0; c < 8; c++) begin
            wr(21'h300, 32'(c) << 20);
            chk("R4 depth", 32'(depth_bpp), 32'(exp_depth(c)));
        end
        wr(21'h300, 32'hA580_0400);
        chk("R4 blank", 32'(blank_force), 1);
        chk("R4 cursor hide", 32'(cursor_hide), 1);
        rd(21'h300, d, e);
        chk("R4 ctrl read", d, 32'hA580_0400);
    endtask

    task automatic t_top_cursor;
        wr(21'h400, 32'hFF12_3456);
        chk("R5 top", 32'(top_ofs), 32'h12_3456);
        wr(21'h638, 32'h000A_B123);
        chk("R5 cursor x", 32'(cursor_x), 32'h0AB);
        chk("R5 cursor y", 32'(cursor_y), 32'h123);
    endtask

    task automatic t_palette;
        wr(21'h800, 32'hFF11_2233);
        wr(21'h80C, 32'h0044_5566);
        wr(21'hFF8, 32'h00AA_BBCC);
        pal_ridx = 8'd0; #1; chk("R6 pal 0", 32'(pal_rgb), 32'h11_2233);
        pal_ridx = 8'd1; #1; chk("R6 pal 1 unaligned", 32'(pal_rgb), 32'h44_5566);
        pal_ridx = 8'd255; #1; chk("R6 pal 255", 32'(pal_rgb), 32'hAA_BBCC);
    endtask

    task automatic t_cursor_pal;
        wr(21'h510, 32'h0001_0203);
        wr(21'h518, 32'h0004_0506);
        cpal_ridx = 2'd1; #1; chk("R7 cpal 1", 32'(cpal_rgb), 32'h01_0203);
        cpal_ridx = 2'd2; #1; chk("R7 cpal 2", 32'(cpal_rgb), 32'h04_0506);
        cpal_ridx = 2'd3; #1; chk("R7 cpal 3", 32'(cpal_rgb), 0);
    endtask

    task automatic t_pattern;
        wr(21'h1FF8, 32'hABCD_1234);
        wr(21'h1008, 32'h0000_BEEF);
        pat_ridx = 9'd511; #1; chk("R8 pat 511", 32'(pat_word), 32'h1234);
        pat_ridx = 9'd1; #1; chk("R8 pat 1", 32'(pat_word), 32'hBEEF);
    endtask

    task automatic t_ignored_err;
        logic [31:0] d; logic e;
        wr(21'h108, 32'hFFFF_FFFF);
        wr(21'h200, 32'hFFFF_FFFF);
        chk("R9 ignored ctrl", ctrl_word, 32'hA580_0400);
        chk("R9 ignored width", 32'(width_px), 32'hFFC);
        rd(21'h400, d, e);
        chk("R9 write-only data", d, 0);
        chk("R9 write-only err", 32'(e), 1);
        @(negedge clk);
        chk("R9 err one cycle", 32'(bus_err), 0);
        rd(21'h600, d, e);
        chk("R9 unmapped err", 32'(e), 1);
        rd(21'h800, d, e);
        chk("R9 palette read err", 32'(e), 1);
        chk("R9 palette read data", d, 0);
    endtask

    task automatic t_partial;
        logic [31:0] d; logic e;
        @(negedge clk); frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        wr(21'h300, 32'h0000_0000, 4'h3);
        chk("R10 ctrl kept", ctrl_word, 32'hA580_0400);
        chk("R10 irq kept", 32'(irq), 1);
        wr(21'h800, 32'h0099_9999, 4'h1);
        pal_ridx = 8'd0; #1; chk("R10 pal kept", 32'(pal_rgb), 32'h11_2233);
        rd(21'h300, d, e, 4'hC);
        chk("R10 read data", d, 0);
        chk("R10 read err", 32'(e), 0);
    endtask

    task automatic t_irq;
        wr(21'h108, 32'h0);
        chk("R12 write clears", 32'(irq), 0);
        @(negedge clk); frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        chk("R12 frame sets", 32'(irq), 1);
        @(negedge clk);
        bus_addr = 21'h400; bus_wdata = 32'h0; bus_wr = 1'b1; frame_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; frame_done = 1'b0;
        chk("R12 set wins", 32'(irq), 1);
    endtask

    task automatic t_dirty;
        @(negedge clk); dirty_ack = 1'b1; @(negedge clk); dirty_ack = 1'b0;
        chk("R13 ack clears", 32'(disp_dirty), 0);
        wr(21'h300, 32'hA580_0400);
        chk("R13 ctrl no dirty", 32'(disp_dirty), 0);
        wr(21'h1000, 32'h1);
        chk("R13 pattern sets", 32'(disp_dirty), 1);
        @(negedge clk);
        bus_addr = 21'h808; bus_wdata = 32'h7; bus_wr = 1'b1; dirty_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; dirty_ack = 1'b0;
        chk("R13 set wins", 32'(disp_dirty), 1);
        @(negedge clk); dirty_ack = 1'b1; @(negedge clk); dirty_ack = 1'b0;
    endtask

    task automatic t_soft_reset;
        @(negedge clk); frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        wr(21'h100000, 32'h0);
        chk("R11 width", 32'(width_px), 0);
        chk("R11 height", 32'(height_ln), 0);
        chk("R11 ctrl", ctrl_word, 0);
        chk("R11 top", 32'(top_ofs), 0);
        chk("R11 cursor", 32'({cursor_x, cursor_y}), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 dirty", 32'(disp_dirty), 1);
        pal_ridx = 8'd255; cpal_ridx = 2'd2; pat_ridx = 9'd511; #1;
        chk("R11 pal", 32'(pal_rgb), 0);
        chk("R11 cpal", 32'(cpal_rgb), 0);
        chk("R11 pat", 32'(pat_word), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_width();
        t_height();
        t_ctrl();
        t_top_cursor();
        t_palette();
        t_cursor_pal();
        t_pattern();
        t_ignored_err();
        t_partial();
        t_irq();
        t_dirty();
        t_soft_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule